// File: doc/BRIEF.md
# UART Burst Status and Word-Wide FIFO Port

This block is the host-facing register front end of a UART that keeps a byte FIFO for receive and a byte FIFO for transmit, each `DEPTH` entries deep (256 by default). A host on a simple strobe bus can move data one byte at a time through the classic data register, or four bytes per 32-bit access through separate receive and transmit burst registers. A single packed status word tells the host how many bytes it may read, how many it may write, whether an interrupt is pending, and the current line status. The host can read it first and then size a run of burst and byte accesses to match.

The serial side is reduced to byte interfaces. The receive shifter offers one byte per cycle, with parity and framing error qualifiers. The transmit shifter takes one byte per cycle on a valid/ready handshake. Overrun is sticky and is cleared only by a specific FIFO-control write. Parity and framing flags are cleared when the status word is read.

Top module: `uart_burst_port`

## Requirements
- R1: After reset both FIFOs are empty, `tx_valid_o` is low and the status word (offset 0x9C) reads 0x6010FF00.
- R2: Status bits 7:0 give the receive fill level and bits 15:8 the free transmit slots, each saturated at 255.
- R3: Status bit 24 is set when receive data is present, bits 29 and 30 when the transmit FIFO is empty, and bit 31 when parity or framing error is set. Bit 20 is set only when no receive data and no error flag is present. Bits 19:16, 23:21 and 28 read zero.
- R4: A read of offset 0xA4 returns up to four of the oldest receive bytes with the oldest in bits 7:0, and pops them in the same access.
- R5: When fewer than four receive bytes are held, a read of 0xA4 returns only those bytes, zero in the upper lanes, and pops only those bytes. On an empty FIFO it returns 0.
- R6: A read of offset 0x00 returns the oldest receive byte in bits 7:0 and pops one byte. On an empty FIFO it returns 0 and pops nothing.
- R7: A write to offset 0xA0 pushes four bytes with bits 7:0 first. A write to 0x00 pushes bits 7:0 as one byte.
- R8: A burst write with fewer than four free slots keeps only the low lanes that fit and sets overrun (status bit 25). A byte write to a full transmit FIFO is dropped and sets overrun.
- R9: A received byte that arrives when the receive FIFO held `DEPTH` bytes at the start of the cycle is dropped and sets overrun.
- R10: Overrun is sticky and is cleared only by writing 0x43 to offset 0x02. Any other value has no effect. A new overrun in the same cycle as the clear leaves it set.
- R11: A byte accepted with its parity (or framing) qualifier sets status bit 26 (or 27). A status read returns the flag and clears it, unless a new error arrives in that same cycle.
- R12: `tx_valid_o` is high while the transmit FIFO holds data, and `tx_data_o` is the oldest byte. One byte pops on each cycle with valid and ready.
- R13: A receive push and a host pop in the same cycle both take effect: the fill level changes by one minus the bytes popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read strobe |
| rx_valid_i | input | 1 | Receive shifter delivers a byte |
| rx_data_i | input | 8 | Received byte |
| rx_perr_i | input | 1 | Received byte has a parity error |
| rx_ferr_i | input | 1 | Received byte has a framing error |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_ready_i | input | 1 | Transmit shifter takes the byte |

## Verification
Two collisions are provoked on purpose. In the first, a byte from the receive shifter lands in the same cycle as a host burst read. The bench drives both strobes in one cycle and expects the read to return the four older bytes. It then expects the fill level to read two, and the next burst read to return the leftover byte followed by the newly arrived one. In the second, a clearing event meets a new setting event in one cycle. This is an overrun clear written while a byte arrives into a full receive FIFO, or a status read while a parity-errored byte arrives. The bench judges each case by reading the status word afterwards and expecting the flag still set.

// File: rtl/uart_bfp_pkg.sv
package uart_bfp_pkg;
  localparam int unsigned LANES = 4;

  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_FCTL = 8'h02;
  localparam logic [7:0] OFS_STAT = 8'h9C;
  localparam logic [7:0] OFS_TXB  = 8'hA0;
  localparam logic [7:0] OFS_RXB  = 8'hA4;

  localparam logic [7:0] FCTL_OVR_CLR = 8'h43;

  typedef logic [LANES-1:0][7:0] lanes_t;
endpackage

// File: rtl/bfp_fifo.sv
module bfp_fifo
  import uart_bfp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    push_n_i,
  input  lanes_t        push_data_i,
  input  logic [2:0]    pop_n_i,
  output lanes_t        peek_o,
  output logic [CW-1:0] count_o
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  // caller guarantees push_n_i <= free and pop_n_i <= count
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < push_n_i) mem_q[wptr_q + AW'(i)] <= push_data_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + AW'(push_n_i);
      rptr_q <= rptr_q + AW'(pop_n_i);
      cnt_q  <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek_o[g] = mem_q[rptr_q + AW'(g)];
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/bfp_status.sv
module bfp_status #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic          ovr_set_i,
  input  logic          ovr_clr_i,
  input  logic          perr_set_i,
  input  logic          ferr_set_i,
  input  logic          err_clr_i,
  output logic [31:0]   stat_o,
  output logic          ovr_o,
  output logic          perr_o,
  output logic          ferr_o
);
  logic ovr_q, perr_q, ferr_q;

  function automatic logic [7:0] sat8(input logic [CW-1:0] v);
    logic [31:0] w;
    w = 32'(v);
    return (w > 32'd255) ? 8'hFF : w[7:0];
  endfunction

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      ovr_q  <= ovr_set_i  | (ovr_q  & ~ovr_clr_i);
      perr_q <= perr_set_i | (perr_q & ~err_clr_i);
      ferr_q <= ferr_set_i | (ferr_q & ~err_clr_i);
    end
  end

  logic [CW-1:0] tx_free;
  logic          rx_any, tx_empty;

  always_comb begin
    tx_free  = CW'(DEPTH) - tx_cnt_i;
    rx_any   = (rx_cnt_i != '0);
    tx_empty = (tx_cnt_i == '0);
    stat_o        = '0;
    stat_o[7:0]   = sat8(rx_cnt_i);
    stat_o[15:8]  = sat8(tx_free);
    stat_o[20]    = ~(rx_any | ovr_q | perr_q | ferr_q);
    stat_o[24]    = rx_any;
    stat_o[25]    = ovr_q;
    stat_o[26]    = perr_q;
    stat_o[27]    = ferr_q;
    stat_o[29]    = tx_empty;
    stat_o[30]    = tx_empty;
    stat_o[31]    = perr_q | ferr_q;
  end

  assign ovr_o  = ovr_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
endmodule

// File: rtl/uart_burst_port.sv
module uart_burst_port
  import uart_bfp_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_perr_i,
  input  logic        rx_ferr_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i
);
  localparam int CW = $clog2(DEPTH + 1);

  logic rd, wr;
  logic hit_data, hit_fctl, hit_stat, hit_txb, hit_rxb;

  assign rd       = req_i & ~we_i;
  assign wr       = req_i & we_i;
  assign hit_data = (addr_i == OFS_DATA);
  assign hit_fctl = (addr_i == OFS_FCTL);
  assign hit_stat = (addr_i == OFS_STAT);
  assign hit_txb  = (addr_i == OFS_TXB);
  assign hit_rxb  = (addr_i == OFS_RXB);

  // receive path
  logic [CW-1:0] rx_cnt;
  lanes_t        rx_peek, rx_push_data;
  logic [2:0]    rx_push_n, rx_pop_n, rx_avail;
  logic          rx_full, rx_take;

  assign rx_full      = (rx_cnt == CW'(DEPTH));
  assign rx_take      = rx_valid_i & ~rx_full;
  assign rx_push_n    = {2'b00, rx_take};
  assign rx_push_data = lanes_t'({24'h0, rx_data_i});
  assign rx_avail     = (rx_cnt >= CW'(4)) ? 3'd4 : 3'(rx_cnt);

  always_comb begin
    rx_pop_n = 3'd0;
    if (rd && hit_rxb)                      rx_pop_n = rx_avail;
    else if (rd && hit_data && rx_cnt != '0) rx_pop_n = 3'd1;
  end

  bfp_fifo #(.DEPTH(DEPTH), .CW(CW)) u_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_n_i    (rx_push_n),
    .push_data_i (rx_push_data),
    .pop_n_i     (rx_pop_n),
    .peek_o      (rx_peek),
    .count_o     (rx_cnt)
  );

  // transmit path
  logic [CW-1:0] tx_cnt, tx_free;
  lanes_t        tx_peek, tx_push_data;
  logic [2:0]    tx_push_n, tx_room, tx_pop_n;
  logic          tx_drop;

  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign tx_room = (tx_free >= CW'(4)) ? 3'd4 : 3'(tx_free);

  always_comb begin
    tx_push_n    = 3'd0;
    tx_push_data = lanes_t'(wdata_i);
    tx_drop      = 1'b0;
    if (wr && hit_txb) begin
      tx_push_n = tx_room;
      tx_drop   = (tx_room != 3'd4);
    end else if (wr && hit_data) begin
      tx_push_n    = (tx_free != '0) ? 3'd1 : 3'd0;
      tx_push_data = lanes_t'({24'h0, wdata_i[7:0]});
      tx_drop      = (tx_free == '0);
    end
  end

  assign tx_valid_o = (tx_cnt != '0);
  assign tx_data_o  = tx_peek[0];
  assign tx_pop_n   = {2'b00, tx_valid_o & tx_ready_i};

  bfp_fifo #(.DEPTH(DEPTH), .CW(CW)) u_tx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_n_i    (tx_push_n),
    .push_data_i (tx_push_data),
    .pop_n_i     (tx_pop_n),
    .peek_o      (tx_peek),
    .count_o     (tx_cnt)
  );

  // status and sticky flags
  logic [31:0] stat_word;
  logic        ovr_flag, perr_flag, ferr_flag;

  bfp_status #(.DEPTH(DEPTH), .CW(CW)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_cnt_i   (rx_cnt),
    .tx_cnt_i   (tx_cnt),
    .ovr_set_i  ((rx_valid_i & rx_full) | tx_drop),
    .ovr_clr_i  (wr & hit_fctl & (wdata_i[7:0] == FCTL_OVR_CLR)),
    .perr_set_i (rx_take & rx_perr_i),
    .ferr_set_i (rx_take & rx_ferr_i),
    .err_clr_i  (rd & hit_stat),
    .stat_o     (stat_word),
    .ovr_o      (ovr_flag),
    .perr_o     (perr_flag),
    .ferr_o     (ferr_flag)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (hit_stat) begin
        rdata_o = stat_word;
      end else if (hit_rxb) begin
        for (int i = 0; i < LANES; i++) begin
          if (3'(i) < rx_avail) rdata_o[8*i +: 8] = rx_peek[i];
        end
      end else if (hit_data && rx_cnt != '0) begin
        rdata_o[7:0] = rx_peek[0];
      end
    end
  end
endmodule

// File: rtl/uart_burst_port_chk.sv
module uart_burst_port_chk #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [7:0]    addr_i,
  input logic [7:0]    wbyte_i,
  input logic          rx_valid_i,
  input logic          rx_perr_i,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          ovr_flag,
  input logic          perr_flag
);
  logic rx_full_push, fctl_clr, stat_rd, rxb_rd;

  assign rx_full_push = rx_valid_i && (rx_cnt == CW'(DEPTH));
  assign fctl_clr     = req_i && we_i && addr_i == 8'h02 && wbyte_i == 8'h43;
  assign stat_rd      = req_i && !we_i && addr_i == 8'h9C;
  assign rxb_rd       = req_i && !we_i && addr_i == 8'hA4;

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      a_r2_count_bounds: assert (rx_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH))
        else $error("count beyond depth");
    end
  end

  a_r9_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_push && !req_i) |=> (ovr_flag && rx_cnt == $past(rx_cnt)));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fctl_clr && !rx_full_push) |=> !ovr_flag);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_flag && !fctl_clr) |=> ovr_flag);

  a_r11_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !(rx_valid_i && rx_perr_i)) |=> !perr_flag);

  a_r4_burst_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxb_rd && rx_cnt >= CW'(4) && !rx_valid_i) |=> rx_cnt == $past(rx_cnt) - CW'(4));

  a_r12_tx_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !(req_i && we_i)) |=> tx_cnt == $past(tx_cnt) - CW'(1));
endmodule

bind uart_burst_port uart_burst_port_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wbyte_i    (wdata_i[7:0]),
  .rx_valid_i (rx_valid_i),
  .rx_perr_i  (rx_perr_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .rx_cnt     (rx_cnt),
  .tx_cnt     (tx_cnt),
  .ovr_flag   (ovr_flag),
  .perr_flag  (perr_flag)
);

// File: tb/uart_burst_port_bench.sv
`timescale 1ns/1ps
module uart_burst_port_bench;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;

  int checks = 0, failures = 0;
  logic [7:0] txq[$];

  always #2 clk = ~clk;

  uart_burst_port #(.DEPTH(DEPTH)) u_uart_burst_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_perr = pe; rx_ferr = fe;
    @(posedge clk); #1 rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic tx_drain(input int n, input string rq);
    @(negedge clk);
    tx_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk({rq, " tx_valid"}, 32'(tx_valid), 32'd1);
      chk({rq, " tx_data"}, 32'(tx_data), 32'(txq.pop_front()));
      @(negedge clk);
    end
    tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(8'h9C, d);
    chk("R1 reset status", d, 32'h6010FF00);
    chk("R1 R12 reset tx_valid", 32'(tx_valid), 32'd0);
  endtask

  task automatic t_byte_rx;
    logic [31:0] d;
    rx_put(8'hA1, 1'b0, 1'b0);
    bus_rd(8'h9C, d);
    chk("R2 R3 status one rx byte", d, 32'h6100FF01);
    bus_rd(8'h00, d);
    chk("R6 byte read", d, 32'h000000A1);
    bus_rd(8'h00, d);
    chk("R6 byte read empty", d, 32'h0);
    bus_rd(8'h9C, d);
    chk("R6 no pop on empty", d[7:0], 8'h00);
  endtask

  task automatic t_burst_rx;
    logic [31:0] d;
    for (int i = 1; i <= 6; i++) rx_put(8'(i * 8'h11), 1'b0, 1'b0);
    bus_rd(8'hA4, d);
    chk("R4 burst read order", d, 32'h44332211);
    bus_rd(8'hA4, d);
    chk("R5 partial burst pad", d, 32'h00006655);
    bus_rd(8'h9C, d);
    chk("R5 popped only present", d[7:0], 8'h00);
    bus_rd(8'hA4, d);
    chk("R5 burst read empty", d, 32'h0);
  endtask

  task automatic t_line_err;
    logic [31:0] d;
    rx_put(8'h01, 1'b1, 1'b0);
    bus_rd(8'h9C, d);
    chk("R11 R3 parity flagged", d, 32'hE500FF01);
    bus_rd(8'h9C, d);
    chk("R11 parity cleared by read", d, 32'h6100FF01);
    rx_put(8'h02, 1'b0, 1'b1);
    // status read collides with a new parity-errored byte
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h9C;
    rx_valid = 1'b1; rx_data = 8'h03; rx_perr = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 req = 1'b0; rx_valid = 1'b0; rx_perr = 1'b0;
    chk("R11 R3 framing flagged", d, 32'hE900FF02);
    bus_rd(8'h9C, d);
    chk("R11 new parity wins over clear", d[31:24], 8'hE5);
    bus_rd(8'h9C, d);
    chk("R11 all cleared", d[31:24], 8'h61);
    bus_rd(8'hA4, d);
    chk("R5 drain three", d, 32'h00030201);
  endtask

  task automatic t_concurrent;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) rx_put(8'(8'h10 + i), 1'b0, 1'b0);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'hA4;
    rx_valid = 1'b1; rx_data = 8'h15;
    #1 d = rdata;
    @(posedge clk); #1 req = 1'b0; rx_valid = 1'b0;
    chk("R13 burst read beside push", d, 32'h13121110);
    bus_rd(8'h9C, d);
    chk("R13 fill after collision", d[7:0], 8'h02);
    bus_rd(8'hA4, d);
    chk("R13 leftover plus new", d, 32'h00001514);
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    bus_wr(8'hA0, 32'hDDCCBBAA);
    txq.push_back(8'hAA); txq.push_back(8'hBB); txq.push_back(8'hCC); txq.push_back(8'hDD);
    bus_wr(8'h00, 32'h123456EE);
    txq.push_back(8'hEE);
    bus_rd(8'h9C, d);
    chk("R2 R3 tx free after five", d, 32'h0010FB00);
    tx_drain(5, "R7 R12 drain order");
    chk("R12 idle after drain", 32'(tx_valid), 32'd0);
  endtask

  task automatic t_tx_overflow;
    logic [31:0] d;
    for (int i = 0; i < DEPTH / 4; i++) begin
      bus_wr(8'hA0, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
      for (int k = 0; k < 4; k++) txq.push_back(8'(4*i+k));
    end
    bus_rd(8'h9C, d);
    chk("R2 tx full free zero", d, 32'h00100000);
    bus_wr(8'h00, 32'h99);
    bus_rd(8'h9C, d);
    chk("R8 byte write to full", d[25], 1'b1);
    bus_wr(8'h02, 32'h42);
    bus_rd(8'h9C, d);
    chk("R10 other value keeps overrun", d[25], 1'b1);
    bus_wr(8'h02, 32'h43);
    bus_rd(8'h9C, d);
    chk("R10 clear by 0x43", d[25], 1'b0);
    tx_drain(2, "R12 partial drain");
    bus_wr(8'hA0, 32'h44434241);
    txq.push_back(8'h41); txq.push_back(8'h42);
    bus_rd(8'h9C, d);
    chk("R8 partial burst overrun", d[25], 1'b1);
    chk("R8 partial burst filled", d[15:8], 8'h00);
    bus_wr(8'h02, 32'h43);
    tx_drain(DEPTH, "R8 R7 drain after drop");
    bus_rd(8'h9C, d);
    chk("R3 tx empty again", d, 32'h6010FF00);
  endtask

  task automatic t_rx_overflow;
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) rx_put(8'(i), 1'b0, 1'b0);
    bus_rd(8'h9C, d);
    chk("R2 rx count saturates", d[7:0], 8'hFF);
    chk("R9 no overrun yet", d[25], 1'b0);
    // overflow byte collides with the overrun clear
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h02; wdata = 32'h43;
    rx_valid = 1'b1; rx_data = 8'h5A;
    @(posedge clk); #1 req = 1'b0; we = 1'b0; rx_valid = 1'b0;
    bus_rd(8'h9C, d);
    chk("R9 R10 set wins over clear", d[25], 1'b1);
    bus_wr(8'h02, 32'h43);
    bus_rd(8'h9C, d);
    chk("R10 cleared", d[25], 1'b0);
    for (int i = 0; i < DEPTH / 4; i++) begin
      bus_rd(8'hA4, d);
      chk("R4 R9 burst drain", d, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    end
    bus_rd(8'h9C, d);
    chk("R9 dropped byte absent", d[7:0], 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_byte_rx();
    t_burst_rx();
    t_line_err();
    t_concurrent();
    t_tx_basic();
    t_tx_overflow();
    t_rx_overflow();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule